// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the memory-side address stream for a multi-register load or store. Given a 16-bit register selection mask, a base address, an addressing mode and a writeback enable, it issues one word address per clock for every selected register. It names the register that owns each word and marks whether the access is the first (non-sequential) one of the burst or a follow-on (sequential) one. At the end it pulses a completion flag and, when asked, presents the updated base value once.

Whatever the mode, the sequencer always walks memory upwards. For the decrementing modes it first subtracts the whole block size from the base, so it finds the lowest address up front. The lowest-numbered selected register always lands at the lowest address. The data path, the memory and any abort or exception handling sit outside this block.

Top module: `lsm_addr_seq`

## Requirements
- R1: Bit i of `regList` selects register i. Each set bit yields exactly one word cycle (`memValid` high) with `regIdx` = i, and a clear bit yields none.
- R2: Word cycles run on consecutive clocks, starting the cycle after `start` is sampled. `regIdx` rises strictly and `memAddr` rises by 4 from each word to the next.
- R3: With k set bits, the first address is set by `mode`. 0 (increment-after) gives base. 1 (increment-before) gives base+4. 2 (decrement-after) gives base-4k+4. 3 (decrement-before) gives base-4k. All arithmetic is modulo 2^32.
- R4: `seqCycle` is 0 on the first word of a burst and 1 on every later word.
- R5: When `wbEn` was high at start, `wbValid` is high for exactly one cycle, together with `done`. In that cycle `wbAddr` is base+4k for modes 0 and 1 and base-4k for modes 2 and 3. When `wbEn` was low, `wbValid` stays low.
- R6: `done` is a single-cycle pulse in the cycle after the last word, and never coincides with `memValid`. An empty list gives no word cycles and raises `done` in the cycle after `start`.
- R7: Bits [1:0] of `memAddr` are 0 on every word cycle, even for an unaligned base.
- R8: A `start` raised while a transfer or its completion cycle is in progress is ignored. The running burst's addresses, indices and writeback are unchanged.
- R9: After reset, `memValid`, `done` and `wbValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| regList | input | 16 | Register selection mask, bit i = register i |
| baseAddr | input | 32 | Base address |
| mode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| wbEn | input | 1 | Request an updated base at the end |
| memValid | output | 1 | A word address is presented this cycle |
| memAddr | output | 32 | Word address, low two bits zero |
| regIdx | output | 4 | Register served by the current word |
| seqCycle | output | 1 | 0 = non-sequential first word, 1 = sequential |
| done | output | 1 | One-cycle completion pulse |
| wbValid | output | 1 | `wbAddr` carries the new base this cycle |
| wbAddr | output | 32 | Updated base value |

## Verification
Several properties are checked on every clock: alignment of each issued address, the +4 step and rising register index between back-to-back words, the non-sequential first word with sequential words after it, the one-cycle completion pulse, and writeback occurring only alongside completion. Other behaviour depends on the inputs captured at start, so only the scenarios in the bench can show it. This covers the exact starting address for each of the four modes, the writeback value and its suppression, the handling of an empty or full mask, wrap-around below zero, and a start that arrives mid-burst and must be ignored.

// File: rtl/lsm_seq_pkg.sv
package lsm_seq_pkg;

  typedef enum logic [1:0] {
    MODE_INC_AFTER  = 2'd0,
    MODE_INC_BEFORE = 2'd1,
    MODE_DEC_AFTER  = 2'd2,
    MODE_DEC_BEFORE = 2'd3
  } xferMode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
  } seqCtrl_t;

endpackage

// File: rtl/lsmseq_datapath.sv
module lsmseq_datapath
  import lsm_seq_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  seqCtrl_t                    ctrl,
  input  logic [NUM_REGS-1:0]         regList,
  input  logic [ADDR_W-1:0]           baseAddr,
  input  xferMode_e                   mode,
  output logic [ADDR_W-1:0]           curAddr,
  output logic [$clog2(NUM_REGS)-1:0] curIdx,
  output logic                        firstWord,
  output logic                        listEmpty,
  output logic                        lastWord,
  output logic [ADDR_W-1:0]           wbAddr
);

  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int CNT_W = $clog2(NUM_REGS + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
  localparam logic [NUM_REGS-1:0] ONE_BIT = NUM_REGS'(1);

  logic [NUM_REGS-1:0] pendMask;
  logic [ADDR_W-1:0]   addrReg;
  logic                firstReg;
  logic [ADDR_W-1:0]   wbReg;

  logic [CNT_W-1:0]    setCount;
  logic [ADDR_W-1:0]   span;
  logic [ADDR_W-1:0]   startAddr;
  logic [ADDR_W-1:0]   wbNext;
  logic [NUM_REGS-1:0] lowBit;
  logic [IDX_W-1:0]    lowIdx;

  // number of selected registers
  always_comb begin
    setCount = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      setCount = setCount + CNT_W'(regList[i]);
    end
  end

  assign span = ADDR_W'(setCount) << 2;

  // lowest address of the block, always walked upwards afterwards
  always_comb begin
    unique case (mode)
      MODE_INC_AFTER:  startAddr = baseAddr;
      MODE_INC_BEFORE: startAddr = baseAddr + STEP;
      MODE_DEC_AFTER:  startAddr = baseAddr - span + STEP;
      default:         startAddr = baseAddr - span;
    endcase
  end

  assign wbNext = mode[1] ? (baseAddr - span) : (baseAddr + span);

  // isolate the lowest pending register
  assign lowBit = pendMask & (~pendMask + ONE_BIT);

  always_comb begin
    lowIdx = '0;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (pendMask[i]) lowIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendMask <= '0;
      addrReg  <= '0;
      firstReg <= 1'b0;
      wbReg    <= '0;
    end else if (ctrl.load) begin
      pendMask <= regList;
      addrReg  <= startAddr;
      firstReg <= 1'b1;
      wbReg    <= wbNext;
    end else if (ctrl.advance) begin
      pendMask <= pendMask & ~lowBit;
      addrReg  <= addrReg + STEP;
      firstReg <= 1'b0;
    end
  end

  assign listEmpty = (regList == '0);
  assign lastWord  = ((pendMask & ~lowBit) == '0);
  assign curAddr   = {addrReg[ADDR_W-1:2], 2'b00};
  assign curIdx    = lowIdx;
  assign firstWord = firstReg;
  assign wbAddr    = wbReg;

endmodule

// File: rtl/lsmseq_control.sv
module lsmseq_control
  import lsm_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     wbEn,
  input  logic     listEmpty,
  input  logic     lastWord,
  output seqCtrl_t ctrl,
  output logic     memValid,
  output logic     done,
  output logic     wbValid
);

  seqState_e state, stateNext;
  logic      wbKeep;

  always_comb begin
    stateNext    = state;
    ctrl.load    = 1'b0;
    ctrl.advance = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.load = 1'b1;
          stateNext = listEmpty ? ST_FIN : ST_XFER;
        end
      end
      ST_XFER: begin
        ctrl.advance = 1'b1;
        if (lastWord) stateNext = ST_FIN;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      wbKeep <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctrl.load) wbKeep <= wbEn;
    end
  end

  assign memValid = (state == ST_XFER);
  assign done     = (state == ST_FIN);
  assign wbValid  = (state == ST_FIN) && wbKeep;

endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
  import lsm_seq_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [NUM_REGS-1:0]         regList,
  input  logic [ADDR_W-1:0]           baseAddr,
  input  logic [1:0]                  mode,
  input  logic                        wbEn,
  output logic                        memValid,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [$clog2(NUM_REGS)-1:0] regIdx,
  output logic                        seqCycle,
  output logic                        done,
  output logic                        wbValid,
  output logic [ADDR_W-1:0]           wbAddr
);

  seqCtrl_t ctrl;
  logic     listEmpty;
  logic     lastWord;
  logic     firstWord;

  lsmseq_control uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .wbEn     (wbEn),
    .listEmpty(listEmpty),
    .lastWord (lastWord),
    .ctrl     (ctrl),
    .memValid (memValid),
    .done     (done),
    .wbValid  (wbValid)
  );

  lsmseq_datapath #(
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W)
  ) uDp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .regList  (regList),
    .baseAddr (baseAddr),
    .mode     (xferMode_e'(mode)),
    .curAddr  (memAddr),
    .curIdx   (regIdx),
    .firstWord(firstWord),
    .listEmpty(listEmpty),
    .lastWord (lastWord),
    .wbAddr   (wbAddr)
  );

  assign seqCycle = ~firstWord;

endmodule

// File: rtl/lsm_addr_seq_chk.sv
module lsm_addr_seq_chk #(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        memValid,
  input logic [ADDR_W-1:0]           memAddr,
  input logic [$clog2(NUM_REGS)-1:0] regIdx,
  input logic                        seqCycle,
  input logic                        done,
  input logic                        wbValid
);

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    memValid |-> (memAddr[1:0] == 2'b00)); // R7

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && $past(memValid)) |-> (memAddr == $past(memAddr) + ADDR_W'(4))); // R2

  AST_IDX_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && $past(memValid)) |-> (regIdx > $past(regIdx))); // R2

  AST_FIRST_NONSEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && !$past(memValid)) |-> !seqCycle); // R4

  AST_LATER_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && $past(memValid)) |-> seqCycle); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_NOT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && memValid)); // R6

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> done); // R5

endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(
  .NUM_REGS(NUM_REGS),
  .ADDR_W  (ADDR_W)
) uChk (
  .clk     (clk),
  .rst_n   (rst_n),
  .memValid(memValid),
  .memAddr (memAddr),
  .regIdx  (regIdx),
  .seqCycle(seqCycle),
  .done    (done),
  .wbValid (wbValid)
);

// File: tb/sim_lsm_addr_seq.sv
module sim_lsm_addr_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  idx;
    logic        seq;
  } wordExp_t;

  typedef struct packed {
    logic        wb;
    logic [31:0] addr;
  } finExp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] regList = '0;
  logic [31:0] baseAddr = '0;
  logic [1:0]  mode = '0;
  logic        wbEn = 1'b0;
  logic        memValid;
  logic [31:0] memAddr;
  logic [3:0]  regIdx;
  logic        seqCycle;
  logic        done;
  logic        wbValid;
  logic [31:0] wbAddr;

  wordExp_t wordQ[$];
  finExp_t  finQ[$];
  int checks = 0;
  int errors = 0;
  int doneCount = 0;
  int cycles = 0;
  bit monOn = 1'b0;

  lsm_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .regList(regList),
    .baseAddr(baseAddr), .mode(mode), .wbEn(wbEn),
    .memValid(memValid), .memAddr(memAddr), .regIdx(regIdx),
    .seqCycle(seqCycle), .done(done), .wbValid(wbValid), .wbAddr(wbAddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // driver: compute expected stream from the requirements and launch
  task automatic runTx(input logic [15:0] lst, input logic [31:0] base,
                       input logic [1:0] md, input logic wb, input bit poke);
    int k;
    logic [31:0] a;
    bit first;
    int target;
    k = $countones(lst);
    case (md)
      2'd0: a = base;                       // R3
      2'd1: a = base + 32'd4;
      2'd2: a = base - 32'(4 * k) + 32'd4;
      default: a = base - 32'(4 * k);
    endcase
    first = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (lst[i]) begin
        wordQ.push_back('{addr: {a[31:2], 2'b00}, idx: 4'(i), seq: !first});
        a = a + 32'd4;
        first = 1'b0;
      end
    end
    finQ.push_back('{wb: wb, addr: md[1] ? base - 32'(4 * k) : base + 32'(4 * k)});
    target = doneCount + 1;
    @(negedge clk);
    regList = lst; baseAddr = base; mode = md; wbEn = wb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R8: a start in mid-burst with different inputs must be ignored
      @(negedge clk);
      regList = 16'hFFFF; baseAddr = 32'hDEAD_0000; mode = 2'd3; wbEn = ~wb; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (doneCount >= target);
  endtask

  // monitor: compare outputs away from the active edge
  always @(negedge clk) begin
    if (monOn) begin
      if (memValid) begin
        if (wordQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R1: unexpected word actual idx %0d expected none", regIdx);
        end else begin
          wordExp_t e;
          e = wordQ.pop_front();
          check("R3/R2 address", memAddr, e.addr);
          check("R1 register index", 32'(regIdx), 32'(e.idx));
          check("R4 sequential flag", 32'(seqCycle), 32'(e.seq));
          check("R7 alignment", 32'(memAddr[1:0]), 32'd0);
        end
      end
      if (done) begin
        finExp_t f;
        check("R6 all words issued before done", 32'(wordQ.size()), 32'd0);
        if (finQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6: unexpected done actual 1 expected 0");
        end else begin
          f = finQ.pop_front();
          check("R5 writeback valid", 32'(wbValid), 32'(f.wb));
          if (f.wb) check("R5 writeback value", wbAddr, f.addr);
        end
        doneCount++;
      end
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 memValid after reset", 32'(memValid), 32'd0);
    check("R9 done after reset", 32'(done), 32'd0);
    check("R9 wbValid after reset", 32'(wbValid), 32'd0);
    monOn = 1'b1;

    runTx(16'h000F, 32'h0000_1000, 2'd0, 1'b1, 1'b0); // R3 inc-after
    runTx(16'h8001, 32'h0000_2000, 2'd1, 1'b1, 1'b0); // R3 inc-before, sparse R1
    runTx(16'h00F0, 32'h0000_3000, 2'd2, 1'b1, 1'b0); // R3 dec-after
    runTx(16'hFFFF, 32'h0000_4000, 2'd3, 1'b1, 1'b0); // R3 dec-before, full list
    runTx(16'h0000, 32'h0000_5000, 2'd0, 1'b1, 1'b0); // R6 empty list
    runTx(16'h0400, 32'h0000_6000, 2'd3, 1'b1, 1'b0); // single word R4
    runTx(16'h0A50, 32'h0000_7000, 2'd0, 1'b0, 1'b0); // R5 no writeback
    runTx(16'h0303, 32'h0000_1002, 2'd1, 1'b1, 1'b0); // R7 unaligned base
    runTx(16'hFFFF, 32'h0000_0008, 2'd3, 1'b1, 1'b0); // R3 wrap below zero
    runTx(16'h0F0F, 32'h0000_9000, 2'd2, 1'b1, 1'b1); // R8 start while busy

    // R6: empty list done lands exactly one cycle after start
    @(negedge clk);
    regList = '0; mode = 2'd0; wbEn = 1'b0; start = 1'b1;
    finQ.push_back('{wb: 1'b0, addr: 32'd0});
    @(negedge clk);
    start = 1'b0;
    check("R6 empty-list done timing", 32'(done), 32'd1);
    @(negedge clk);
    check("R6 done is one cycle", 32'(done), 32'd0);

    repeat (3) @(negedge clk);
    check("R8 nothing left pending", 32'(wordQ.size() + finQ.size()), 32'd0);
    finishRun();
  end

endmodule